// File: doc/BRIEF.md
# Vertical-interval timecode line deframer

This block takes the bit stream of one vertical-interval timecode line after slicing and bit recovery have already happened. Each recovered bit arrives with a one-cycle strobe, and a separate pulse marks the start of a line. A line is 90 bits long and is built from nine ten-bit groups. Each group is a sync pair (a 1 and then a 0) followed by eight payload bits. The deframer checks and removes the sync pairs and packs the payload of every group into one byte. The last group carries the transmitted check byte. That byte is stored like any other, on the upper byte lane of the output.

The sync bits never reach the byte outputs, but the check byte still covers them. An internal accumulator therefore runs on the raw bit stream. It uses generator x^8+1, which is the same as eight interleaved parity lanes: line bit i toggles lane i mod 8, for line bits 0 through 81. When the final bit of a line has been taken, the nine bytes, the computed check byte and a data-available flag all update on one clock edge. A host can compare the computed check byte with byte 8. A one-cycle clear request returns every readback output to zero.

A small state machine sequences the work. Its states are:
- ST_IDLE: waits for a line start and ignores bits.
- ST_SYNC_HI: expects the 1 of a sync pair.
- ST_SYNC_LO: expects the 0 of a sync pair.
- ST_DATA: collects eight payload bits.
- ST_COMMIT: a one-cycle state in which the outputs load.

The transitions are:
- A line-start pulse moves the machine to ST_SYNC_HI from any state.
- In ST_SYNC_HI, a correct bit moves it to ST_SYNC_LO and a wrong bit moves it to ST_IDLE.
- In ST_SYNC_LO, a correct bit moves it to ST_DATA and a wrong bit moves it to ST_IDLE.
- In ST_DATA, the eighth bit moves it to ST_SYNC_HI, or to ST_COMMIT after the ninth byte.
- ST_COMMIT always moves to ST_IDLE.

Top module: `tc_line_deframer`

## Requirements
- R1: After reset, and on the clock edge after a clear request, `rx_bytes_o`, `calc_chk_o` and `avail_o` are all zero.
- R2: A strobed bit is ignored unless a line start has armed the deframer. A bit strobed in the same cycle as `line_start_i` is also ignored. The first strobe after the pulse carries line bit 0.
- R3: Each ten-bit group is a 1, then a 0, then eight payload bits. The payload of group k goes to `rx_bytes_o[8k+7:8k]`, and the earliest payload bit received lands in bit 8k.
- R4: Line bits 82 to 89 are the transmitted check byte. They appear unchanged on `rx_bytes_o[71:64]`, with line bit 82 in bit 64.
- R5: `calc_chk_o[j]` is the XOR of every line bit i in the range 0 to 81 with i mod 8 = j. Sync bits are included.
- R6: The clock edge after the strobe that carries line bit 89 updates all byte outputs and `calc_chk_o` together and sets `avail_o` to 1. Before that edge, the outputs still show the previous line.
- R7: If any sync bit differs from its expected value, the line is dropped. The outputs and `avail_o` keep their values, and later bits are ignored until the next line start.
- R8: A line-start pulse in the middle of a line discards the partial line and restarts the bit position and the check accumulator.
- R9: A clear request in the same cycle as a line completion wins: the outputs go to zero and `avail_o` to 0.
- R10: Outputs change only on a line completion or a clear.
- R11: A later good line overwrites the outputs, and `avail_o` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | Strobe: `bit_i` holds a recovered bit this cycle |
| bit_i | input | 1 | Recovered line bit |
| line_start_i | input | 1 | One-cycle pulse marking the start of a line |
| clear_i | input | 1 | One-cycle request to zero the readback outputs |
| rx_bytes_o | output | 72 | Nine received bytes, byte k on bits [8k+7:8k] |
| calc_chk_o | output | 8 | Check byte computed over line bits 0 to 81 |
| avail_o | output | 1 | A line has completed since the last clear |

## Verification
The hardest case to reach from the ports is a clear request that lands in the single ST_COMMIT cycle. That cycle exists only on the clock after line bit 89 is taken, so the bench pulses `clear_i` exactly one cycle after the final strobe of a complete line. Sync faults are swept across all eighteen sync positions by flipping one sync bit in an otherwise good line. Line restarts are placed at early, middle and last-bit positions. The main sweep runs 256 distinct payload patterns, with and without strobe gaps, and computes the expected check byte arithmetically.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    // Sequencer states of the line deframer
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNC_HI = 3'd1,
        ST_SYNC_LO = 3'd2,
        ST_DATA    = 3'd3,
        ST_COMMIT  = 3'd4
    } tcd_state_e;

endpackage

// File: rtl/tcd_sequencer.sv
module tcd_sequencer
    import tcd_pkg::*;
#(
    parameter int NUM_BYTES = 9,
    parameter int DATA_BITS = 8,
    localparam int BIDX_W   = $clog2(NUM_BYTES),
    localparam int DIDX_W   = $clog2(DATA_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              line_start_i,
    output logic              data_we_o,
    output logic [BIDX_W-1:0] byte_sel_o,
    output logic              chk_en_o,
    output logic              chk_clr_o,
    output logic              commit_o
);

    localparam logic [BIDX_W-1:0] LAST_B = BIDX_W'(NUM_BYTES - 1);
    localparam logic [DIDX_W-1:0] LAST_D = DIDX_W'(DATA_BITS - 1);

    tcd_state_e        state_q, state_d;
    logic [BIDX_W-1:0] byte_q, byte_d;
    logic [DIDX_W-1:0] didx_q, didx_d;
    logic              strobe;

    assign strobe = bit_vld_i && !line_start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            didx_q  <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            didx_q  <= didx_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        didx_d  = didx_q;
        if (line_start_i) begin
            state_d = ST_SYNC_HI;
            byte_d  = '0;
            didx_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_SYNC_HI: begin
                    if (bit_vld_i) begin
                        state_d = bit_i ? ST_SYNC_LO : ST_IDLE;
                    end
                end
                ST_SYNC_LO: begin
                    if (bit_vld_i) begin
                        state_d = bit_i ? ST_IDLE : ST_DATA;
                        didx_d  = '0;
                    end
                end
                ST_DATA: begin
                    if (bit_vld_i) begin
                        if (didx_q == LAST_D) begin
                            didx_d = '0;
                            if (byte_q == LAST_B) begin
                                state_d = ST_COMMIT;
                            end else begin
                                byte_d  = byte_q + BIDX_W'(1);
                                state_d = ST_SYNC_HI;
                            end
                        end else begin
                            didx_d = didx_q + DIDX_W'(1);
                        end
                    end
                end
                ST_COMMIT: begin
                    state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        data_we_o  = 1'b0;
        chk_en_o   = 1'b0;
        commit_o   = 1'b0;
        chk_clr_o  = line_start_i;
        byte_sel_o = byte_q;
        unique case (state_q)
            ST_IDLE: begin
                data_we_o = 1'b0;
            end
            ST_SYNC_HI, ST_SYNC_LO: begin
                chk_en_o = strobe;
            end
            ST_DATA: begin
                data_we_o = strobe;
                chk_en_o  = strobe && (byte_q != LAST_B);
            end
            ST_COMMIT: begin
                commit_o = 1'b1;
            end
            default: begin
                commit_o = 1'b0;
            end
        endcase
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !line_start_i) |=> state_q == ST_IDLE);

    // R7
    sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_HI && bit_vld_i && !bit_i && !line_start_i) |=> state_q == ST_IDLE);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> (state_q == ST_SYNC_HI && byte_q == '0 && didx_q == '0));

    // R6
    last_bit_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && strobe && byte_q == LAST_B && didx_q == LAST_D) |=> commit_o);

endmodule

// File: rtl/tcd_check_acc.sv
module tcd_check_acc #(
    parameter int CRC_W   = 8,
    localparam int PH_W   = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] acc_o
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CRC_W - 1);

    logic [PH_W-1:0]  phase_q;
    logic [CRC_W-1:0] acc_q;

    // Lane pointer: running bit index modulo the check width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr_i) begin
            phase_q <= '0;
        end else if (en_i) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + PH_W'(1);
        end
    end

    // One parity lane per check bit (x^N + 1 division)
    for (genvar g = 0; g < CRC_W; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= 1'b0;
            end else if (clr_i) begin
                acc_q[g] <= 1'b0;
            end else if (en_i && phase_q == PH_W'(g)) begin
                acc_q[g] <= acc_q[g] ^ bit_i;
            end
        end
    end

    assign acc_o = acc_q;

    // R5
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> $countones(acc_q ^ $past(acc_q)) <= 1);

    // R8
    acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_q == '0);

endmodule

// File: rtl/tcd_byte_store.sv
module tcd_byte_store #(
    parameter int NUM_BYTES = 9,
    parameter int DATA_BITS = 8,
    localparam int BIDX_W   = $clog2(NUM_BYTES),
    localparam int TOTAL_W  = NUM_BYTES * DATA_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [BIDX_W-1:0]  sel_i,
    input  logic               bit_i,
    output logic [TOTAL_W-1:0] bytes_o
);

    // Shadow bytes: each shifts right so the earliest bit ends in bit 0
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        logic [DATA_BITS-1:0] shadow_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (we_i && sel_i == BIDX_W'(k)) begin
                shadow_q <= {bit_i, shadow_q[DATA_BITS-1:1]};
            end
        end
        assign bytes_o[k*DATA_BITS +: DATA_BITS] = shadow_q;
    end

    // R3
    shadow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(bytes_o));

endmodule

// File: rtl/tc_line_deframer.sv
module tc_line_deframer
    import tcd_pkg::*;
#(
    parameter int NUM_BYTES = 9,
    parameter int DATA_BITS = 8,
    parameter int CRC_W     = 8,
    localparam int BIDX_W   = $clog2(NUM_BYTES),
    localparam int TOTAL_W  = NUM_BYTES * DATA_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_vld_i,
    input  logic               bit_i,
    input  logic               line_start_i,
    input  logic               clear_i,
    output logic [TOTAL_W-1:0] rx_bytes_o,
    output logic [CRC_W-1:0]   calc_chk_o,
    output logic               avail_o
);

    logic              data_we;
    logic [BIDX_W-1:0] byte_sel;
    logic              chk_en;
    logic              chk_clr;
    logic              commit;
    logic [TOTAL_W-1:0] shadow_bytes;
    logic [CRC_W-1:0]   acc_val;

    tcd_sequencer #(
        .NUM_BYTES (NUM_BYTES),
        .DATA_BITS (DATA_BITS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .line_start_i (line_start_i),
        .data_we_o    (data_we),
        .byte_sel_o   (byte_sel),
        .chk_en_o     (chk_en),
        .chk_clr_o    (chk_clr),
        .commit_o     (commit)
    );

    tcd_check_acc #(
        .CRC_W (CRC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (chk_clr),
        .en_i  (chk_en),
        .bit_i (bit_i),
        .acc_o (acc_val)
    );

    tcd_byte_store #(
        .NUM_BYTES (NUM_BYTES),
        .DATA_BITS (DATA_BITS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (data_we),
        .sel_i   (byte_sel),
        .bit_i   (bit_i),
        .bytes_o (shadow_bytes)
    );

    // Readback registers: clear wins over a completing line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_bytes_o <= '0;
            calc_chk_o <= '0;
            avail_o    <= 1'b0;
        end else if (clear_i) begin
            rx_bytes_o <= '0;
            calc_chk_o <= '0;
            avail_o    <= 1'b0;
        end else if (commit) begin
            rx_bytes_o <= shadow_bytes;
            calc_chk_o <= acc_val;
            avail_o    <= 1'b1;
        end
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (rx_bytes_o == '0 && calc_chk_o == '0 && !avail_o));

    // R9
    clear_over_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && commit) |=> !avail_o);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !commit) |=> ($stable(rx_bytes_o) && $stable(calc_chk_o) && $stable(avail_o)));

    // R6
    avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_o) |-> $past(commit));

endmodule

// File: tb/tc_line_deframer_bench.sv
module tc_line_deframer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_vld_i;
    logic        bit_i;
    logic        line_start_i;
    logic        clear_i;
    logic [71:0] rx_bytes_o;
    logic [7:0]  calc_chk_o;
    logic        avail_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [71:0] exp_bytes;
    logic [7:0]  exp_chk;
    logic        exp_avail;

    always #10 clk = ~clk;

    tc_line_deframer u_tc_line_deframer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .line_start_i (line_start_i),
        .clear_i      (clear_i),
        .rx_bytes_o   (rx_bytes_o),
        .calc_chk_o   (calc_chk_o),
        .avail_o      (avail_o)
    );

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [89:0] build_line(input logic [71:0] b);
        logic [89:0] l;
        l = '0;
        for (int k = 0; k < 9; k++) begin
            l[10*k]     = 1'b1;
            l[10*k + 1] = 1'b0;
            for (int j = 0; j < 8; j++) l[10*k + 2 + j] = b[8*k + j];
        end
        return l;
    endfunction

    function automatic logic [7:0] calc_check(input logic [89:0] l);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < 82; i++) c[i % 8] = c[i % 8] ^ l[i];
        return c;
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_all(input string rb, input string rc, input string ra);
        chk(rb, rx_bytes_o, exp_bytes);
        chk(rc, {64'h0, calc_chk_o}, {64'h0, exp_chk});
        chk(ra, {71'h0, avail_o}, {71'h0, exp_avail});
    endtask

    task automatic pulse_start();
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
    endtask

    task automatic send_bit(input logic b, input bit gap);
        bit_vld_i = 1'b1;
        bit_i     = b;
        @(negedge clk);
        bit_vld_i = 1'b0;
        if (gap) @(negedge clk);
    endtask

    // Sends bits [0:cnt-1] of a line; returns at the negedge after the last sample edge
    task automatic send_bits(input logic [89:0] l, input int cnt, input bit gaps);
        for (int i = 0; i < cnt; i++) send_bit(l[i], gaps && (i % 4 == 2));
    endtask

    task automatic good_line(input logic [71:0] b, input bit gaps, input string tag);
        logic [89:0] l;
        l = build_line(b);
        pulse_start();
        send_bits(l, 90, gaps);
        // R6 R10: still the old line right after the last bit is taken
        check_all({"R6 R10 hold ", tag}, "R6 R10 hold chk", "R6 R10 hold avail");
        @(negedge clk);
        exp_bytes = b;
        exp_chk   = calc_check(l);
        exp_avail = 1'b1;
    endtask

    initial begin
        logic [71:0] b;
        logic [89:0] l;
        rst_n = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; line_start_i = 1'b0; clear_i = 1'b0;
        exp_bytes = '0; exp_chk = '0; exp_avail = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset bytes", "R1 reset chk", "R1 reset avail");

        // R2: a whole good line without a line start is ignored
        send_bits(build_line(72'hA5A5_1234_5678_9ABC_DE), 90, 1'b0);
        repeat (2) @(negedge clk);
        check_all("R2 unarmed bytes", "R2 unarmed chk", "R2 unarmed avail");

        // R2: the bit strobed together with the start pulse is ignored
        b = 72'h11_2233_4455_6677_8899;
        l = build_line(b);
        line_start_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b0;
        @(negedge clk);
        line_start_i = 1'b0; bit_vld_i = 1'b0;
        send_bits(l, 90, 1'b0);
        @(negedge clk);
        exp_bytes = b; exp_chk = calc_check(l); exp_avail = 1'b1;
        check_all("R2 same-cycle bytes", "R2 same-cycle chk", "R2 same-cycle avail");

        // Payload sweep, R3 R4 R5 R11
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 9; k++) b[8*k +: 8] = 8'((v * 7 + k * 53 + v * k * 3) & 255);
            good_line(b, (v % 2) == 1, "sweep");
            chk("R3 payload bytes", {8'h0, rx_bytes_o[63:0]}, {8'h0, exp_bytes[63:0]});
            chk("R4 check byte lane", {64'h0, rx_bytes_o[71:64]}, {64'h0, exp_bytes[71:64]});
            chk("R5 computed check", {64'h0, calc_chk_o}, {64'h0, exp_chk});
            chk("R11 avail stays", {71'h0, avail_o}, 72'h1);
        end
        good_line('0, 1'b0, "zeros");
        check_all("R3 all-zero bytes", "R5 all-zero chk", "R6 all-zero avail");
        good_line('1, 1'b1, "ones");
        check_all("R3 all-one bytes", "R5 all-one chk", "R6 all-one avail");

        // R7: single sync fault at each of the 18 sync positions
        for (int p = 0; p < 18; p++) begin
            b = {8'(p), 64'hFEDC_BA98_7654_3210} ^ {9{8'(p * 11)}};
            l = build_line(b);
            l[10 * (p / 2) + (p % 2)] = ~l[10 * (p / 2) + (p % 2)];
            pulse_start();
            send_bits(l, 90, 1'b0);
            repeat (2) @(negedge clk);
            check_all("R7 abort bytes", "R7 abort chk", "R7 abort avail");
        end

        // R8: restart in mid-line at several positions
        for (int m = 1; m < 90; m += 11) begin
            pulse_start();
            send_bits(build_line({9{8'(m)}}), m, 1'b0);
            b = {9{8'(255 - m)}} ^ 72'h0F_0E0D_0C0B_0A09_0807;
            good_line(b, 1'b0, "restart");
            check_all("R8 restart bytes", "R8 restart chk", "R8 restart avail");
        end
        pulse_start();
        send_bits(build_line(72'h5A), 89, 1'b0);
        good_line(72'hC3_3C00_FF12_34AB_CD99, 1'b1, "restart89");
        check_all("R8 late restart bytes", "R8 late restart chk", "R8 late restart avail");

        // R1: clear while idle
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        exp_bytes = '0; exp_chk = '0; exp_avail = 1'b0;
        check_all("R1 clear bytes", "R1 clear chk", "R1 clear avail");

        good_line(72'h77_6655_4433_2211_00AA, 1'b0, "post-clear");
        check_all("R6 post-clear bytes", "R5 post-clear chk", "R6 post-clear avail");

        // R9: clear in the commit cycle
        b = 72'h98_7654_3210_FEDC_BA01;
        pulse_start();
        send_bits(build_line(b), 90, 1'b0);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        exp_bytes = '0; exp_chk = '0; exp_avail = 1'b0;
        check_all("R9 clear-wins bytes", "R9 clear-wins chk", "R9 clear-wins avail");
        repeat (3) @(negedge clk);
        check_all("R10 idle hold bytes", "R10 idle hold chk", "R10 idle hold avail");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule